// File: doc/BRIEF.md
# Free-Running Tick Counter with Compare Interrupt

This block keeps a cycle counter that advances by one on every clock and a compare target that raises a sticky interrupt when the counter reaches it. Software writes either the count or the limit through a single write strobe with a select bit. It reads the count back on a combinational read bus.

One bit position of the data word, set by a parameter, is not part of the count. It serves as a shared disable flag. Every write, whether to the count or to the limit, strips that bit from the stored value and copies it into the flag. Reads of the count OR the flag back into that bit position.

The compare arms only when the stripped limit is non-zero and the flag is clear. It fires once per arming. A limit written at or below the current count is not lost: it fires on the very next tick. The interrupt output stays high until a clear strobe is given. Writes are accepted on every cycle, so the write port never applies back-pressure and needs no ready signal.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted the count is zero, the disable flag is set, the compare is disarmed and `irq` is low, so `rd_count` reads as only the flag bit (bit `MASK_BIT`, default 63) set.
- R2: With no count write, the stored count (all bits except `MASK_BIT`) increases by exactly one per clock and wraps to zero without ever touching `MASK_BIT`.
- R3: A write with `wr_sel`=0 loads the count with `wr_data` with bit `MASK_BIT` cleared, and sets the disable flag equal to `wr_data[MASK_BIT]`. `rd_count` returns the count with bit `MASK_BIT` set whenever the flag is set.
- R4: A write with `wr_sel`=1 loads the limit with bit `MASK_BIT` cleared, and sets the disable flag equal to `wr_data[MASK_BIT]`. The flag change is visible on `rd_count[MASK_BIT]` on the next cycle.
- R5: With the compare armed and the flag clear, `irq` goes high on the clock edge after the cycle in which the stored count equals the limit.
- R6: A limit write whose stripped value is zero disarms the compare, and `irq` does not rise from it.
- R7: While the disable flag is set, no match sets `irq`.
- R8: A non-zero enabled limit written while it is at or below the current count sets `irq` on the second clock edge after the write edge, which is one tick later.
- R9: `irq` stays high until `irq_clr` is sampled high. If a match and `irq_clr` occur in the same cycle, the set wins.
- R10: Each arming fires at most once. After a fire, moving the count back below the old limit does not raise `irq` again until a new limit write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe, accepted on every cycle it is high |
| wr_sel | input | 1 | 0 selects the count, 1 selects the limit |
| wr_data | input | WIDTH | Write value including the disable bit |
| irq_clr | input | 1 | Clears the sticky interrupt |
| rd_count | output | WIDTH | Count with the disable flag ORed into bit MASK_BIT |
| irq | output | 1 | Sticky compare interrupt |

## Verification
The compare is driven with three kinds of limit: one ahead of the count, one equal to or behind it, and one that is zero. Together they separate the normal countdown path, the late-arm rule and the disarm rule. Each of these is repeated with the disable bit set, on the count write and on the limit write, to show that the flag alone suppresses the match whatever arming exists. A clear given on the same cycle as a match, and a count rewound below an already-fired limit, tell the set-wins priority and the one-shot arming apart from a level comparator.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tick_sel_e;
endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg #(
  parameter int WIDTH    = 64,
  parameter int MASK_BIT = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ld,
  input  logic [WIDTH-1:0] cnt_ld_val,
  input  logic             flag_ld,
  input  logic             flag_ld_val,
  output logic [WIDTH-1:0] cnt_q,
  output logic             flag_q
);
  localparam logic [WIDTH-1:0] MASK = {{(WIDTH-1){1'b0}}, 1'b1} << MASK_BIT;

  logic [WIDTH-1:0] cnt_inc;

  // Increment variant: a top-bit mask needs only a narrower adder.
  generate
    if (MASK_BIT == WIDTH-1) begin : g_top_mask
      assign cnt_inc = {1'b0, cnt_q[WIDTH-2:0] + {{(WIDTH-2){1'b0}}, 1'b1}};
    end else begin : g_mid_mask
      assign cnt_inc = (cnt_q + {{(WIDTH-1){1'b0}}, 1'b1}) & ~MASK;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      cnt_q <= cnt_ld ? (cnt_ld_val & ~MASK) : cnt_inc;
      if (flag_ld) flag_q <= flag_ld_val;
    end
  end
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int WIDTH    = 64,
  parameter int MASK_BIT = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_ld,
  input  logic [WIDTH-1:0] lim_val,
  input  logic             lim_dis,
  input  logic [WIDTH-1:0] cnt_q,
  input  logic             flag_q,
  output logic             match
);
  localparam logic [WIDTH-1:0] MASK = {{(WIDTH-1){1'b0}}, 1'b1} << MASK_BIT;

  logic [WIDTH-1:0] target_q;
  logic             armed_q;
  logic [WIDTH-1:0] lim_strip;
  logic [WIDTH-1:0] next_cnt;
  logic             late;

  assign lim_strip = lim_val & ~MASK;
  assign next_cnt  = (cnt_q + {{(WIDTH-1){1'b0}}, 1'b1}) & ~MASK;
  assign late      = (lim_strip <= cnt_q);
  assign match     = armed_q && !flag_q && (cnt_q == target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (lim_ld) begin
      target_q <= late ? next_cnt : lim_strip;
      armed_q  <= (lim_strip != '0) && !lim_dis;
    end else if (match) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_irq_latch.sv
module tick_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int WIDTH    = 64,
  parameter int MASK_BIT = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             irq_clr,
  output logic [WIDTH-1:0] rd_count,
  output logic             irq
);
  localparam logic [WIDTH-1:0] MASK = {{(WIDTH-1){1'b0}}, 1'b1} << MASK_BIT;

  tick_sel_e        sel;
  logic             cnt_ld, lim_ld;
  logic [WIDTH-1:0] cnt_q;
  logic             flag_q;
  logic             match;

  assign sel    = tick_sel_e'(wr_sel);
  assign cnt_ld = wr_valid && (sel == SEL_COUNT);
  assign lim_ld = wr_valid && (sel == SEL_LIMIT);

  tick_count_reg #(.WIDTH(WIDTH), .MASK_BIT(MASK_BIT)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_ld      (cnt_ld),
    .cnt_ld_val  (wr_data),
    .flag_ld     (wr_valid),
    .flag_ld_val (wr_data[MASK_BIT]),
    .cnt_q       (cnt_q),
    .flag_q      (flag_q)
  );

  tick_compare #(.WIDTH(WIDTH), .MASK_BIT(MASK_BIT)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lim_ld  (lim_ld),
    .lim_val (wr_data),
    .lim_dis (wr_data[MASK_BIT]),
    .cnt_q   (cnt_q),
    .flag_q  (flag_q),
    .match   (match)
  );

  tick_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (match),
    .clr_i (irq_clr),
    .irq_q (irq)
  );

  assign rd_count = cnt_q | (flag_q ? MASK : '0);
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int WIDTH    = 64,
  parameter int MASK_BIT = 63
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_sel,
  input logic [WIDTH-1:0] wr_data,
  input logic             irq_clr,
  input logic [WIDTH-1:0] rd_count,
  input logic             irq
);
  localparam logic [WIDTH-1:0] MASK = {{(WIDTH-1){1'b0}}, 1'b1} << MASK_BIT;

  p_reset_flag_r1: assert property (@(posedge clk)
    !rst_n |=> rd_count[MASK_BIT] && !irq);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && !wr_sel) |=>
      ((rd_count & ~MASK) == (($past(rd_count) + {{(WIDTH-1){1'b0}}, 1'b1}) & ~MASK)));

  p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel && ((wr_data & ~MASK) == '0)) ##1 !irq |=> !irq);

  p_no_fire_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(rd_count[MASK_BIT]));

  p_late_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel && !wr_data[MASK_BIT] && ((wr_data & ~MASK) != '0)
      && ((wr_data & ~MASK) <= (rd_count & ~MASK))) |=> ##1 irq);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

bind tick_timer tick_timer_chk #(.WIDTH(WIDTH), .MASK_BIT(MASK_BIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .irq_clr  (irq_clr),
  .rd_count (rd_count),
  .irq      (irq)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam logic [63:0] M = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_sel, irq_clr;
  logic [63:0] wr_data;
  logic [63:0] rd_count;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_clr(irq_clr), .rd_count(rd_count), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset count", rd_count, M);
    chk("R1 reset irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_count();
    wr(1'b0, 64'h10);
    chk("R3 count write", rd_count, 64'h10);
    step(1);
    chk("R2 step", rd_count, 64'h11);
    step(5);
    chk("R2 run", rd_count, 64'h16);
    wr(1'b0, M | 64'h20);
    chk("R3 flag reflected", rd_count, M | 64'h20);
    step(1);
    chk("R2 step while disabled", rd_count, M | 64'h21);
    wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
    step(1);
    chk("R2 wrap clear of mask bit", rd_count, 64'h0);
  endtask

  task automatic t_limit_flag();
    wr(1'b0, 64'h40);
    wr(1'b1, M | 64'h48);
    chk("R4 limit sets flag", rd_count, M | 64'h41);
    step(20);
    chk("R4 disabled limit no irq", {63'd0, irq}, 64'd0);
    wr(1'b0, M | 64'h40);
    wr(1'b1, 64'h60);
    chk("R4 limit clears flag", rd_count, 64'h41);
    step(31);
    chk("R5 before match", {63'd0, irq}, 64'd0);
    step(1);
    chk("R5 match fires", {63'd0, irq}, 64'd1);
    clear_irq();
  endtask

  task automatic t_match();
    wr(1'b0, 64'd100);
    wr(1'b1, 64'd110);
    step(9);
    chk("R5 one short", {63'd0, irq}, 64'd0);
    step(1);
    chk("R5 fire", {63'd0, irq}, 64'd1);
    step(5);
    chk("R9 sticky", {63'd0, irq}, 64'd1);
    clear_irq();
    chk("R9 cleared", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_zero();
    wr(1'b0, 64'd5);
    wr(1'b1, 64'd0);
    step(30);
    chk("R6 zero limit", {63'd0, irq}, 64'd0);
    wr(1'b1, M);
    step(10);
    chk("R6 masked zero limit", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_disabled();
    wr(1'b0, 64'd200);
    wr(1'b1, 64'd205);
    wr(1'b0, M | 64'd200);
    step(15);
    chk("R7 disabled no irq", {63'd0, irq}, 64'd0);
    chk("R7 flag seen", rd_count, M | 64'd215);
  endtask

  task automatic t_late();
    wr(1'b0, 64'd300);
    wr(1'b1, 64'd100);
    chk("R8 not yet", {63'd0, irq}, 64'd0);
    step(1);
    chk("R8 late fire", {63'd0, irq}, 64'd1);
    clear_irq();
    wr(1'b0, 64'd290);
    step(20);
    chk("R10 no refire", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_clr_race();
    wr(1'b0, 64'd500);
    wr(1'b1, 64'd500);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 set beats clear", {63'd0, irq}, 64'd1);
    clear_irq();
  endtask

  task automatic t_reset_cancel();
    wr(1'b0, 64'd10);
    wr(1'b1, 64'd14);
    rst_n = 1'b0;
    step(2);
    chk("R1 reset mid-run", rd_count, M);
    rst_n = 1'b1;
    step(10);
    chk("R1 compare cancelled", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_sel = 1'b0; wr_data = '0; irq_clr = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_count();
    t_limit_flag();
    t_match();
    t_zero();
    t_disabled();
    t_late();
    t_clr_race();
    t_reset_cancel();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule